// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a byte-oriented two-wire bus slave that runs entirely on the system clock. It oversamples the clock line and a receive-only data line, and it answers through a separate open-drain pull-down output. Joining the receive input and the pull-down output on one wire gives an ordinary bidirectional data line. Keeping them apart lets the bus pass through one-way isolators. Behind the bus engine sits a small register file of 2^PTR_W bytes. A 3-bit pointer selects the register, and the pointer is loaded from the low bits of the command byte of each transfer.

The slave supports single-byte and two-byte writes and reads. A two-byte write keeps only the first data byte. A two-byte read returns the pointed register twice. The slave also answers two shared addresses. The first is a broadcast write address, which a bit in the control register can switch off. The second is the alert-response address, which is answered only while an alert is pending. In that reply the slave sends its own address and arbitrates bit by bit against other responders. The rest of the chip reads and writes the registers through a plain parallel port.

The clock line is never stretched, so the bus side has no back-pressure. The parallel port has no handshake either: a write takes effect at the next clock edge, and the read data follows the index combinationally.

Top module: `smb_regfile_slave`

## Requirements
- R1: A START (data falling while the clock is high) restarts address reception from any state, including a repeated START in the middle of a transfer. A STOP (data rising while the clock is high) returns the slave to idle with `sda_pull` low. A transfer cut short by a STOP or a restart writes nothing.
- R2: The slave's own address is binary 10 followed by the 5-bit value n = 9*t2 + 3*t1 + t0. Here t2, t1 and t0 come from `addr_pins[5:4]`, `[3:2]` and `[1:0]`, where code 00 gives 0, code 10 gives 2, and codes 01 and 11 give 1. The slave acknowledges its own address by asserting `sda_pull` for the ninth clock, and it never acknowledges a foreign address.
- R3: A write (R/W bit 0) to address 1011111 is acknowledged and performed as if it were addressed to the slave's own address, provided bit 4 of register 0 is 1. When that bit is 0, the broadcast address is not acknowledged and no register changes. A read to the broadcast address is never acknowledged. Register 0 resets to 0x10 and every other register resets to 0x00.
- R4: In a write, the byte after the address is a command byte. Only its bits [2:0] select the register. The next byte, sent MSB first, is acknowledged and stored in the selected register.
- R5: In a two-byte write, the second data byte and any later bytes are acknowledged and leave every register unchanged.
- R6: A read is a command-byte write, then a repeated START, then the same address with R/W bit 1. The slave returns the selected register MSB first. If the master acknowledges that byte, the slave sends the same value again.
- R7: Address 0001100 with R/W bit 1 is acknowledged only while `alert_pend` is 1. The reply byte is the slave's 7-bit own address followed by a 1. `alert_won` pulses for one cycle after the eighth reply bit only if the data line matched every bit the slave sent. If the line is seen low while the slave sends a 1, the slave drops out and does not pulse `alert_won`.
- R8: A parallel write with `hw_we` high stores `hw_wdata` into register `hw_idx` at the next clock edge. `hw_rdata` always shows register `hw_idx`.
- R9: During and straight after reset, `sda_pull` and `alert_won` are 0.
- R10: `sda_pull` only rises while the bus clock is low, so the slave never creates a START or STOP on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as received, asynchronous |
| sda_pull | output | 1 | 1 pulls the data line low |
| addr_pins | input | 6 | Three 2-bit pin codes that select the own address |
| alert_pend | input | 1 | An alert is pending |
| alert_won | output | 1 | One-cycle pulse: the alert-response arbitration was won |
| hw_we | input | 1 | Parallel register write strobe |
| hw_idx | input | PTR_W | Parallel register index |
| hw_wdata | input | 8 | Parallel write data |
| hw_rdata | output | 8 | Contents of register `hw_idx` |

## Verification
The bench uses the default parameters: PTR_W of 3, which gives eight registers, register 0 as the control register with the broadcast enable in bit 4 and a reset value of 0x10, and two synchronizer stages. Eight registers let the bench use command bytes whose upper bits are set, and so confirm that only the low three bits pick the register. Because the control register sits at index 0, the bench can turn broadcast off and back on with one parallel write. With a two-stage synchronizer, the slave reacts within a few system cycles, well inside a bus half-period of ten cycles, so every acknowledge and data bit can be sampled at the middle of the high clock phase.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int BYTE_W = 8;
  localparam logic [6:0] BCAST_ADDR = 7'b1011111;
  localparam logic [6:0] ARA_ADDR   = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_DATA, K_EXTRA
  } kind_t;

  // pin code to trit: 00 low, 10 high, 01/11 open
  function automatic logic [4:0] trit(input logic [1:0] code);
    if (code == 2'b00)      return 5'd0;
    else if (code == 2'b10) return 5'd2;
    else                    return 5'd1;
  endfunction

  function automatic kind_t next_kind(input kind_t k);
    case (k)
      K_ADDR:  return K_CMD;
      K_CMD:   return K_DATA;
      default: return K_EXTRA;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_in};
      sda_sh <= {sda_sh[STAGES-1:0], sda_in};
    end
  end

  assign scl_now = scl_sh[STAGES-1];
  assign scl_old = scl_sh[STAGES];
  assign sda_now = sda_sh[STAGES-1];
  assign sda_old = sda_sh[STAGES];

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/smb_addr_map.sv
module smb_addr_map (
  input  logic [5:0] addr_pins,
  output logic [6:0] own_addr
);
  import smb_pkg::*;
  logic [4:0] low5;
  always_comb begin
    low5 = 5'd9 * trit(addr_pins[5:4]) + 5'd3 * trit(addr_pins[3:2]) + trit(addr_pins[1:0]);
    own_addr = {2'b10, low5};
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int PTR_W = 3,
  parameter int CTRL_IDX = 0,
  parameter logic [7:0] CTRL_RST = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [PTR_W-1:0] bus_idx,
  input  logic [7:0]       bus_wdata,
  input  logic             hw_we,
  input  logic [PTR_W-1:0] hw_idx,
  input  logic [7:0]       hw_wdata,
  output logic [7:0]       regs_q [1<<PTR_W]
);
  localparam int NREG = 1 << PTR_W;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == CTRL_IDX) ? CTRL_RST : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= RST_V;
      else if (bus_we && bus_idx == PTR_W'(g))
        regs_q[g] <= bus_wdata;
      else if (hw_we && hw_idx == PTR_W'(g))
        regs_q[g] <= hw_wdata;
    end
  end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       own_addr,
  input  logic             bcast_en,
  input  logic             alert_pend,
  input  logic [7:0]       rd_byte,
  output logic             sda_pull,
  output logic             alert_won,
  output logic             bus_we,
  output logic [PTR_W-1:0] bus_idx,
  output logic [7:0]       bus_wdata,
  output smb_pkg::phase_t  phase
);
  import smb_pkg::*;

  kind_t      kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txb;
  logic       is_read, is_ara, m_ack;
  logic       hit_own, hit_bc, hit_ara;
  logic [7:0] first_tx;

  always_comb begin
    hit_own  = shreg[7:1] == own_addr;
    hit_bc   = (shreg[7:1] == BCAST_ADDR) && !shreg[0] && bcast_en;
    hit_ara  = (shreg[7:1] == ARA_ADDR) && shreg[0] && alert_pend;
    first_tx = is_ara ? {own_addr, 1'b1} : rd_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_IDLE; kind <= K_ADDR; bitcnt <= '0;
      shreg <= '0; txb <= '0; bus_idx <= '0; bus_wdata <= '0;
      is_read <= 1'b0; is_ara <= 1'b0; m_ack <= 1'b0;
      sda_pull <= 1'b0; alert_won <= 1'b0; bus_we <= 1'b0;
    end else begin
      alert_won <= 1'b0;
      bus_we    <= 1'b0;
      if (stop_det) begin
        phase <= ST_IDLE; sda_pull <= 1'b0;
      end else if (start_det) begin
        phase <= ST_RX; kind <= K_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
      end else begin
        case (phase)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (hit_own || hit_bc || hit_ara) begin
                    phase <= ST_ACK; sda_pull <= 1'b1;
                    is_read <= shreg[0]; is_ara <= hit_ara;
                  end else begin
                    phase <= ST_WAIT;
                  end
                end
                K_CMD: begin
                  bus_idx <= shreg[PTR_W-1:0];
                  phase <= ST_ACK; sda_pull <= 1'b1;
                end
                K_DATA: begin
                  bus_we <= 1'b1; bus_wdata <= shreg;
                  phase <= ST_ACK; sda_pull <= 1'b1;
                end
                default: begin
                  phase <= ST_ACK; sda_pull <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                phase <= ST_TX; txb <= first_tx; sda_pull <= ~first_tx[7];
              end else begin
                phase <= ST_RX; kind <= next_kind(kind); sda_pull <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
              if (is_ara && sda_lvl != txb[7]) begin
                phase <= ST_WAIT; sda_pull <= 1'b0;
              end
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                phase <= ST_MACK; sda_pull <= 1'b0;
                alert_won <= is_ara;
              end else begin
                txb <= {txb[6:0], 1'b0}; sda_pull <= ~txb[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack && !is_ara) begin
                phase <= ST_TX; bitcnt <= '0;
                txb <= rd_byte; sda_pull <= ~rd_byte[7];
              end else begin
                phase <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter int PTR_W = 3,
  parameter int CTRL_IDX = 0,
  parameter int BCAST_BIT = 4,
  parameter logic [7:0] CTRL_RST = 8'h10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic [5:0]       addr_pins,
  input  logic             alert_pend,
  output logic             alert_won,
  input  logic             hw_we,
  input  logic [PTR_W-1:0] hw_idx,
  input  logic [7:0]       hw_wdata,
  output logic [7:0]       hw_rdata
);
  localparam int NREG = 1 << PTR_W;

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] own_addr;
  logic bus_we;
  logic [PTR_W-1:0] bus_idx;
  logic [7:0] bus_wdata;
  logic [7:0] regs_q [NREG];
  smb_pkg::phase_t phase;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_addr_map amap_i (.addr_pins(addr_pins), .own_addr(own_addr));

  smb_regfile #(.PTR_W(PTR_W), .CTRL_IDX(CTRL_IDX), .CTRL_RST(CTRL_RST)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_wdata(hw_wdata),
    .regs_q(regs_q)
  );

  smb_xfer_fsm #(.PTR_W(PTR_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .bcast_en(regs_q[CTRL_IDX][BCAST_BIT]),
    .alert_pend(alert_pend), .rd_byte(regs_q[bus_idx]),
    .sda_pull(sda_pull), .alert_won(alert_won),
    .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .phase(phase)
  );

  assign hw_rdata = regs_q[hw_idx];
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             sda_pull,
  input logic             alert_won,
  input logic             hw_we,
  input logic [PTR_W-1:0] hw_idx,
  input logic [7:0]       hw_wdata,
  input logic             bus_we,
  input logic [PTR_W-1:0] bus_idx,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       regs_q [1<<PTR_W],
  input smb_pkg::phase_t  phase
);
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull && !alert_won));

  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_in));

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == smb_pkg::ST_IDLE) |-> !sda_pull);

  p_won_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_won |=> !alert_won);

  p_bus_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> regs_q[$past(bus_idx)] == $past(bus_wdata));

  p_one_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  p_host_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !(bus_we && bus_idx == hw_idx)) |=> regs_q[$past(hw_idx)] == $past(hw_wdata));
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .alert_won(alert_won), .hw_we(hw_we), .hw_idx(hw_idx), .hw_wdata(hw_wdata),
  .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
  .regs_q(regs_q), .phase(phase)
);

// File: tb/smb_regfile_slave_tb_top.sv
module smb_regfile_slave_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_line, alert_won;
  logic [5:0] addr_pins = 6'b000000;
  logic alert_pend = 1'b0;
  logic hw_we = 1'b0;
  logic [2:0] hw_idx = '0;
  logic [7:0] hw_wdata = '0, hw_rdata;
  int n_chk = 0, n_bad = 0, won_cnt = 0, r10_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  smb_regfile_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_pins(addr_pins), .alert_pend(alert_pend),
    .alert_won(alert_won), .hw_we(hw_we), .hw_idx(hw_idx),
    .hw_wdata(hw_wdata), .hw_rdata(hw_rdata)
  );

  logic pull_d = 1'b0;
  always @(posedge clk) begin
    if (alert_won) won_cnt <= won_cnt + 1;
    if (sda_pull && !pull_d && scl_m) r10_bad <= r10_bad + 1;
    pull_d <= sda_pull;
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(H);
    end
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2); ack = ~sda_line; hw(H/2);
    scl_m = 1'b0; hw(H);
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic give_ack, input int force_bit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = (i == force_bit) ? 1'b0 : 1'b1;
      hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(H); sda_m = 1'b1;
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                         input bit word, input logic [7:0] d2, output logic [3:0] acks);
    bus_start;
    tx_byte({a, 1'b0}, acks[0]);
    tx_byte(cmd, acks[1]);
    tx_byte(d, acks[2]);
    acks[3] = 1'b1;
    if (word) tx_byte(d2, acks[3]);
    bus_stop;
  endtask

  task automatic rd_xfer(input logic [6:0] a, input logic [7:0] cmd, input bit word,
                         output logic [7:0] r0, output logic [7:0] r1, output logic [2:0] acks);
    bus_start;
    tx_byte({a, 1'b0}, acks[0]);
    tx_byte(cmd, acks[1]);
    bus_start;
    tx_byte({a, 1'b1}, acks[2]);
    rx_byte(r0, word, -1);
    r1 = r0;
    if (word) rx_byte(r1, 1'b0, -1);
    bus_stop;
  endtask

  task automatic addr_only(input logic [7:0] ab, output logic ack);
    bus_start; tx_byte(ab, ack); bus_stop;
  endtask

  task automatic host_wr(input logic [2:0] idx, input logic [7:0] d);
    hw_idx = idx; hw_wdata = d; hw_we = 1'b1; hw(1); hw_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] idx, output logic [7:0] d);
    hw_idx = idx; hw(1); d = hw_rdata;
  endtask

  // op[25:24] ptr[23:21] cmd_hi[20:16] data[15:8] alt[7:0]
  // op 0 write byte, 1 write word, 2 read byte, 3 read word
  localparam logic [25:0] VEC [0:5] = '{
    {2'd0, 3'd2, 5'h00, 8'hA5, 8'h00},
    {2'd1, 3'd5, 5'h1F, 8'h3C, 8'hC3},
    {2'd2, 3'd6, 5'h0A, 8'h5A, 8'h00},
    {2'd3, 3'd7, 5'h00, 8'h81, 8'h00},
    {2'd0, 3'd1, 5'h15, 8'hFF, 8'h00},
    {2'd3, 3'd3, 5'h11, 8'h00, 8'h00}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] wa;
    logic [2:0] ra;
    logic [7:0] r0, r1, rv;
    logic a1;
    int w0;

    hw(3);
    chk("R9 pull in reset", sda_pull, 0);
    chk("R9 won in reset", alert_won, 0);
    rst_n = 1'b1;
    hw(2);
    chk("R9 pull after reset", sda_pull, 0);
    host_rd(3'd0, rv); chk("R3 reg0 reset", rv, 8'h10);
    host_rd(3'd4, rv); chk("R3 reg4 reset", rv, 8'h00);

    // table of transfers against own address 0x40
    for (int v = 0; v < 6; v++) begin
      logic [1:0] op; logic [2:0] p; logic [7:0] cmd, d, alt;
      op = VEC[v][25:24]; p = VEC[v][23:21]; cmd = {VEC[v][20:16], p};
      d = VEC[v][15:8]; alt = VEC[v][7:0];
      case (op)
        2'd0, 2'd1: begin
          wr_xfer(7'h40, cmd, d, op == 2'd1, alt, wa);
          chk("R4 write acks", wa, 4'hF);
          host_rd(p, rv);
          chk(op == 2'd1 ? "R5 word keeps first byte" : "R4 byte stored", rv, d);
        end
        default: begin
          host_wr(p, d);
          rd_xfer(7'h40, cmd, op == 2'd3, r0, r1, ra);
          chk("R6 read acks", ra, 3'b111);
          chk("R6 first byte", r0, d);
          if (op == 2'd3) chk("R6 repeated byte", r1, d);
        end
      endcase
    end

    // R8 parallel port
    host_wr(3'd4, 8'h6E);
    chk("R8 host write visible", hw_rdata, 8'h6E);

    // R2 addressing
    addr_only({7'h41, 1'b0}, a1); chk("R2 foreign nack", a1, 0);
    addr_pins = 6'b100100;
    wr_xfer(7'h55, 8'h04, 8'h77, 1'b0, 8'h00, wa);
    chk("R2 pins map to 0x55", wa, 4'hF);
    host_rd(3'd4, rv); chk("R2 write via mapped addr", rv, 8'h77);
    addr_only({7'h40, 1'b0}, a1); chk("R2 old addr nack", a1, 0);
    addr_pins = 6'b111111;
    addr_only({7'h4D, 1'b0}, a1); chk("R2 code 11 as open", a1, 1);
    addr_pins = 6'b000000;

    // R3 broadcast
    wr_xfer(7'h5F, 8'h03, 8'h99, 1'b0, 8'h00, wa);
    chk("R3 bcast acks", wa, 4'hF);
    host_rd(3'd3, rv); chk("R3 bcast stored", rv, 8'h99);
    addr_only({7'h5F, 1'b1}, a1); chk("R3 bcast read nack", a1, 0);
    host_wr(3'd0, 8'h00);
    wr_xfer(7'h5F, 8'h03, 8'h11, 1'b0, 8'h00, wa);
    chk("R3 bcast masked nack", wa[0], 0);
    host_rd(3'd3, rv); chk("R3 masked no change", rv, 8'h99);
    host_wr(3'd0, 8'h10);

    // R1 abort by STOP and repeated START mid-transfer
    bus_start; tx_byte({7'h40, 1'b0}, a1); tx_byte(8'h02, a1); bus_stop;
    chk("R1 released after stop", sda_pull, 0);
    bus_start; tx_byte({7'h40, 1'b0}, a1); tx_byte(8'h02, a1);
    bus_start; tx_byte({7'h40, 1'b0}, a1); tx_byte(8'h06, a1); tx_byte(8'h44, a1);
    bus_stop;
    host_rd(3'd6, rv); chk("R1 restart write lands", rv, 8'h44);
    host_rd(3'd2, rv); chk("R1 aborted write no change", rv, 8'hA5);

    // R7 alert response
    addr_only({7'h0C, 1'b1}, a1); chk("R7 no pend nack", a1, 0);
    alert_pend = 1'b1;
    w0 = won_cnt;
    bus_start; tx_byte({7'h0C, 1'b1}, a1); rx_byte(r0, 1'b0, -1); bus_stop;
    chk("R7 ara ack", a1, 1);
    chk("R7 ara reply", r0, 8'h81);
    chk("R7 won pulse", won_cnt - w0, 1);
    w0 = won_cnt;
    bus_start; tx_byte({7'h0C, 1'b1}, a1); rx_byte(r0, 1'b0, 7); bus_stop;
    chk("R7 lost no pulse", won_cnt - w0, 0);
    alert_pend = 1'b0;

    chk("R10 pull rises only with scl low", r10_bad, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule